// File: doc/BRIEF.md
# Conditional Branch Test Evaluator

This block decides whether a conditional jump is taken. It receives a 4-bit condition code, a data register, a second register that acts as a compare value or a bit mask, and the address of the jump instruction. Only the low byte of each register takes part in the test. The lower three bits of the code choose one of eight tests: three unsigned magnitude comparisons, two tests on the data byte alone, and three tests of the data byte against a mask. The top bit of the code inverts the sense, so the branch is taken when the chosen test is false.

Each evaluation starts with a one-cycle start strobe, and the result is registered. One clock later the block presents the decision. When the branch is not taken, it also presents a write-back request that loads the first register with the instruction address plus four. The calling pipeline owns the program counter and the target calculation. This block only supplies the fall-through value.

Top module: `jt_eval`

## Requirements
- R1: Only bits [7:0] of the data and compare/mask registers affect the result. Bits [15:8] of either register have no effect on take_o.
- R2: With dl = data[7:0] and ml = cmp[7:0] compared as unsigned 8-bit numbers, code 0 tests dl <= ml, code 1 tests dl < ml, and code 2 tests dl == ml.
- R3: Code 3 tests that dl is 0x00. Code 4 tests that dl is 0xFF.
- R4: Code 5 tests that (dl & ml) == ml, meaning the data holds every mask bit. Code 6 tests that (dl & ml) == 0, meaning the data holds none of the mask bits.
- R5: Code 7 tests that (dl & ml) is neither zero nor equal to ml, meaning the data holds some mask bits but not all of them. A zero mask makes this test false.
- R6: Codes 8 to 15 run the same test as the code minus 8. For these codes take_o is the inverse of that test.
- R7: When a result shows the branch as not taken, wb_en_o is 1 and wb_data_o equals the instruction address plus 4, modulo 2^16.
- R8: When a result shows the branch as taken, wb_en_o is 0.
- R9: A start_i pulse sampled at a rising edge gives valid_o = 1 with the result in the following cycle. In a cycle after an edge where start_i was 0, valid_o, take_o and wb_en_o are all 0.
- R10: While rst_ni is low, valid_o, take_o, wb_en_o and wb_data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Evaluate the current inputs |
| cond_i | input | 4 | Condition code; bit 3 inverts the sense |
| data_reg_i | input | 16 | Data register value |
| cmp_reg_i | input | 16 | Compare or mask register value |
| insn_addr_i | input | 16 | Address of the jump instruction |
| valid_o | output | 1 | Result valid this cycle |
| take_o | output | 1 | Branch is taken |
| wb_en_o | output | 1 | Write return address into register 1 |
| wb_data_o | output | 16 | Fall-through return address |

## Verification
The assertions check the timing contract on every cycle: a result follows each start strobe and only a start strobe, write-back and take are exclusive, the return address tracks the sampled instruction address, and the equal and zero-byte tests resolve correctly in both polarities. The bench alone can show the full set of codes. It runs directed boundary values (equal, off-by-one, 0x00, 0xFF, zero mask, partial mask) and a fixed-seed random sweep, with the upper bytes scrambled to confirm they are ignored. It also covers address wrap and the values held during reset.

// File: rtl/jt_pkg.sv
package jt_pkg;

  typedef enum logic [2:0] {
    TST_LE    = 3'd0,
    TST_LT    = 3'd1,
    TST_EQ    = 3'd2,
    TST_ZERO  = 3'd3,
    TST_ONES  = 3'd4,
    TST_ALLM  = 3'd5,
    TST_NOM   = 3'd6,
    TST_PARTM = 3'd7
  } tst_e;

  typedef struct packed {
    logic le;
    logic lt;
    logic eq;
  } cmp_flags_t;

  typedef struct packed {
    logic zero;
    logic ones;
    logic all_m;
    logic no_m;
    logic part_m;
  } mask_flags_t;

endpackage

// File: rtl/jt_cmp_unit.sv
module jt_cmp_unit
  import jt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output cmp_flags_t   flags_o
);

  logic lt, eq;

  // unsigned magnitude
  assign lt = a_i < b_i;
  assign eq = a_i == b_i;

  assign flags_o.lt = lt;
  assign flags_o.eq = eq;
  assign flags_o.le = lt | eq;

endmodule

// File: rtl/jt_mask_unit.sv
module jt_mask_unit
  import jt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output mask_flags_t  flags_o
);

  logic [W-1:0] hit;   // mask bits present in data
  logic [W-1:0] miss;  // mask bits absent from data

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit[i]  = data_i[i] & mask_i[i];
    assign miss[i] = mask_i[i] & ~data_i[i];
  end

  assign flags_o.zero   = ~|data_i;
  assign flags_o.ones   = &data_i;
  assign flags_o.all_m  = ~|miss;
  assign flags_o.no_m   = ~|hit;
  assign flags_o.part_m = (|hit) & (|miss);

endmodule

// File: rtl/jt_decide.sv
module jt_decide
  import jt_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] cond_i,
  input  cmp_flags_t        cmp_i,
  input  mask_flags_t       msk_i,
  output logic              take_o
);

  localparam int SEL_W = COND_W - 1;

  tst_e sel;
  logic tst;

  assign sel = tst_e'(cond_i[SEL_W-1:0]);

  always_comb begin
    unique case (sel)
      TST_LE:    tst = cmp_i.le;
      TST_LT:    tst = cmp_i.lt;
      TST_EQ:    tst = cmp_i.eq;
      TST_ZERO:  tst = msk_i.zero;
      TST_ONES:  tst = msk_i.ones;
      TST_ALLM:  tst = msk_i.all_m;
      TST_NOM:   tst = msk_i.no_m;
      TST_PARTM: tst = msk_i.part_m;
      default:   tst = 1'b0;
    endcase
  end

  // top code bit: branch on false
  assign take_o = tst ^ cond_i[COND_W-1];

endmodule

// File: rtl/jt_eval.sv
module jt_eval
  import jt_pkg::*;
#(
  parameter int REG_W   = 16,
  parameter int TEST_W  = 8,
  parameter int ADDR_W  = 16,
  parameter int COND_W  = 4,
  parameter int RET_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [REG_W-1:0]  data_reg_i,
  input  logic [REG_W-1:0]  cmp_reg_i,
  input  logic [ADDR_W-1:0] insn_addr_i,
  output logic              valid_o,
  output logic              take_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_data_o
);

  localparam logic [ADDR_W-1:0] RetOfs = ADDR_W'(RET_OFS);

  logic [TEST_W-1:0] data_lo, cmp_lo;
  cmp_flags_t        cmp_flags;
  mask_flags_t       msk_flags;
  logic              take_d;
  logic [ADDR_W-1:0] ret_addr;

  assign data_lo  = data_reg_i[TEST_W-1:0];
  assign cmp_lo   = cmp_reg_i[TEST_W-1:0];
  assign ret_addr = insn_addr_i + RetOfs;

  jt_cmp_unit #(.W(TEST_W)) i_cmp (
    .a_i     (data_lo),
    .b_i     (cmp_lo),
    .flags_o (cmp_flags)
  );

  jt_mask_unit #(.W(TEST_W)) i_mask (
    .data_i  (data_lo),
    .mask_i  (cmp_lo),
    .flags_o (msk_flags)
  );

  jt_decide #(.COND_W(COND_W)) i_decide (
    .cond_i  (cond_i),
    .cmp_i   (cmp_flags),
    .msk_i   (msk_flags),
    .take_o  (take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      take_o    <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_data_o <= '0;
    end else begin
      valid_o <= start_i;
      take_o  <= start_i & take_d;
      wb_en_o <= start_i & ~take_d;
      if (start_i) wb_data_o <= ret_addr;
    end
  end

endmodule

// File: rtl/jt_eval_chk.sv
module jt_eval_chk #(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 16,
  parameter int COND_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [COND_W-1:0] cond_i,
  input logic [REG_W-1:0]  data_reg_i,
  input logic [REG_W-1:0]  cmp_reg_i,
  input logic [ADDR_W-1:0] insn_addr_i,
  input logic              valid_o,
  input logic              take_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_data_o
);

  // R9
  start_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && !take_o && !wb_en_o));

  // R8
  take_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (wb_en_o == !take_o));

  // R7
  ret_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !take_o) |=> (!wb_en_o || wb_data_o == $past(insn_addr_i) + ADDR_W'(4)));

  // R2
  eq_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cond_i[2:0] == 3'd2 && data_reg_i[7:0] == cmp_reg_i[7:0])
      |=> (take_o == !$past(cond_i[3])));

  // R3
  zero_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cond_i[2:0] == 3'd3 && data_reg_i[7:0] != 8'h00)
      |=> (take_o == $past(cond_i[3])));

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && !take_o && !wb_en_o && wb_data_o == '0);
    end
  end

endmodule

bind jt_eval jt_eval_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .COND_W(COND_W)) i_jt_eval_chk (.*);

// File: tb/test_jt_eval.sv
module test_jt_eval;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cond = '0;
  logic [15:0] data_reg = '0, cmp_reg = '0, insn_addr = '0;
  logic        valid, take, wb_en;
  logic [15:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jt_eval i_jt_eval (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .cond_i      (cond),
    .data_reg_i  (data_reg),
    .cmp_reg_i   (cmp_reg),
    .insn_addr_i (insn_addr),
    .valid_o     (valid),
    .take_o      (take),
    .wb_en_o     (wb_en),
    .wb_data_o   (wb_data)
  );

  function automatic bit exp_take(input logic [3:0] c, input logic [15:0] d, input logic [15:0] m);
    logic [7:0] dl, ml, h;
    bit t;
    dl = d[7:0];
    ml = m[7:0];
    h  = dl & ml;
    case (c[2:0])
      3'd0: t = dl <= ml;
      3'd1: t = dl < ml;
      3'd2: t = dl == ml;
      3'd3: t = dl == 8'h00;
      3'd4: t = dl == 8'hFF;
      3'd5: t = h == ml;
      3'd6: t = h == 8'h00;
      default: t = (h != 8'h00) && (h != ml);
    endcase
    return t ^ c[3];
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c[3]) return "R6";
    case (c[2:0])
      3'd0, 3'd1, 3'd2: return "R2";
      3'd3, 3'd4:       return "R3";
      3'd5, 3'd6:       return "R4";
      default:          return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] c, input logic [15:0] d, input logic [15:0] m,
                     input logic [15:0] a, input string req);
    bit e;
    logic [15:0] ra;
    @(negedge clk);
    cond = c; data_reg = d; cmp_reg = m; insn_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data_reg = 16'($urandom); cmp_reg = 16'($urandom); insn_addr = 16'($urandom);
    e  = exp_take(c, d, m);
    ra = a + 16'd4;
    check(valid === 1'b1 && take === e, req, {30'd0, valid, take}, {30'd0, 1'b1, e});
    if (e) check(wb_en === 1'b0, "R8", {31'd0, wb_en}, 32'd0);
    else   check(wb_en === 1'b1 && wb_data === ra, "R7", {15'd0, wb_en, wb_data}, {15'd0, 1'b1, ra});
  endtask

  task automatic idle_chk();
    @(negedge clk);
    check(valid === 1'b0 && take === 1'b0 && wb_en === 1'b0, "R9",
          {29'd0, valid, take, wb_en}, 32'd0);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10
    check(valid === 1'b0 && take === 1'b0 && wb_en === 1'b0 && wb_data === 16'h0, "R10",
          {13'd0, valid, take, wb_en, wb_data}, 32'd0);
    rst_n = 1'b1;
    idle_chk();

    // directed: every code, both polarities, boundary values
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [3:0] c;
        c = 4'(p * 8 + k);
        run(c, {8'($urandom), 8'h40}, {8'($urandom), 8'h40}, 16'h1000, req_of(c));
        run(c, {8'($urandom), 8'h3F}, {8'($urandom), 8'h40}, 16'h2000, req_of(c));
        run(c, {8'($urandom), 8'h41}, {8'($urandom), 8'h40}, 16'h3000, req_of(c));
        run(c, {8'($urandom), 8'h00}, {8'($urandom), 8'h00}, 16'h4000, req_of(c));
        run(c, {8'($urandom), 8'hFF}, {8'($urandom), 8'h81}, 16'h5000, req_of(c));
        run(c, {8'($urandom), 8'h01}, {8'($urandom), 8'h81}, 16'h6000, req_of(c));
        run(c, {8'($urandom), 8'h7E}, {8'($urandom), 8'h81}, 16'h7000, req_of(c));
      end
    end
    idle_chk();

    // R1: upper bytes ignored
    run(4'h2, 16'h12AB, 16'h34AB, 16'h0100, "R1");
    run(4'h0, 16'h0180, 16'hFF7F, 16'h0200, "R1");
    run(4'h1, 16'hFF10, 16'h0011, 16'h0300, "R1");
    run(4'h5, 16'h000F, 16'hF00F, 16'h0400, "R1");
    // R7: address wrap
    run(4'h2, 16'h0001, 16'h0002, 16'hFFFE, "R7");
    run(4'hA, 16'h0003, 16'h0003, 16'hFFFC, "R7");
    // R5: zero mask never partial
    run(4'h7, 16'h00FF, 16'h0000, 16'h0010, "R5");
    run(4'hF, 16'h00FF, 16'h0000, 16'h0020, "R5");
    idle_chk();

    // random sweep
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] c;
      logic [15:0] d, m;
      c = 4'($urandom);
      d = 16'($urandom);
      m = 16'($urandom);
      if (($urandom % 4) == 0) d[7:0] = m[7:0];
      if (($urandom % 8) == 0) d[7:0] = d[7:0] | m[7:0];
      run(c, d, m, 16'($urandom), req_of(c));
      if ((i % 100) == 0) idle_chk();
    end

    finish_up();
  end

endmodule